// File: doc/BRIEF.md
# Raster-Timed Colour-Set Switcher

This block follows the horizontal position on a display scanline and changes a colour-set select level at byte columns that the host has programmed. It runs on the chroma-rate clock. The block divides that clock by four to get a CPU-cycle count, so one CPU cycle equals one display byte. A scanline lasts 227.5 chroma periods. The block therefore alternates between 227-clock and 228-clock lines, so that each line holds 57 CPU cycles. On a 227-clock line the last CPU cycle is one chroma clock shorter.

The first visible byte comes 13 CPU cycles after the start of the line. The visible area is 32 bytes wide. An alternate timing mode moves the visible window, and every switch point with it, four CPU cycles earlier. The host loads up to eight switch entries, each holding an arm bit, a byte column and a colour-set value. The entries are double-buffered and go live only at a line start, so no line mixes old and new settings. A rising edge on horizontal sync restarts the line at once. Without sync, the line timing runs freely.

Top module: `raster_css_switcher`

## Requirements
- R1: While `rst_n` is low, `css`, `byte_col`, `visible` and `line_start` are all 0.
- R2: `line_start` pulses for one clock at each line start. Line lengths alternate between 227 and 228 chroma clocks. The first line after reset, and the first line after a sync restart, are 227 clocks long.
- R3: A CPU cycle lasts four chroma clocks from the line start: cycle c covers clocks 4c to 4c+3, counted from the strobe cycle. In normal mode, `visible` is high and `byte_col` = c-13 for cycles 14 to 45. Outside that window `visible` is low and `byte_col` is 0.
- R4: In alternate mode, `visible` is high and `byte_col` = c-9 for cycles 10 to 41.
- R5: An armed entry with column n (1..32) drives `css` to its value on the edge where `byte_col` becomes n. In normal mode that edge is 4*(13+n) clocks after the strobe.
- R6: In alternate mode the same entry fires 4*(9+n) clocks after the strobe, which is 16 chroma clocks earlier than in normal mode.
- R7: When several armed entries share a column, the entry with the highest index (`wr_idx`, 0..7) decides `css`.
- R8: `css` keeps its value across line boundaries until another switch point fires.
- R9: A disarmed entry (`wr_arm`=0), or an entry with column 0 or a column above 32, never changes `css`.
- R10: A write (`wr_en` high for one clock, with `wr_idx`, `wr_arm`, `wr_col`, `wr_css`) has no effect on the current line. It takes effect from the next `line_start`.
- R11: A rising edge on `hsync` restarts the line. On the next clock `line_start` is 1 and `byte_col` is 0. If `hsync` stays high, no further strobe follows.
- R12: `alt_mode` is sampled only at a line start. A change in the middle of a line does not move that line's window or its switch points.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_chroma | input | 1 | Chroma-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Horizontal sync; a rising edge restarts the line |
| alt_mode | input | 1 | 1 = window and switch points four CPU cycles earlier |
| wr_en | input | 1 | Switch-table write strobe |
| wr_idx | input | 3 | Entry index to write |
| wr_arm | input | 1 | Entry enable |
| wr_col | input | 6 | Byte column, 1..32 valid |
| wr_css | input | 1 | Colour-set value applied when the entry fires |
| css | output | 1 | Colour-set select level |
| byte_col | output | 6 | Current visible byte column, 0 outside the window |
| visible | output | 1 | High inside the visible window |
| line_start | output | 1 | One-clock strobe at each line start |

## Verification
The embedded properties check four things on every cycle: the cycle count stays in range and moves only by one or back to zero, a sync edge forces a restart, the active table changes only on a strobe, and `css` changes only inside the visible window. The exact strobe spacing of 228 and 227 clocks cannot be shown by those properties, and neither can the chroma clock on which each switch lands in either mode. The same holds for highest-index priority, the rejection of out-of-range columns, and the deferral of writes and of the mode bit. The bench scenarios show these by predicting each `css` transition and its clock offset within the line.

// File: rtl/css_pkg.sv
package css_pkg;
   localparam int COL_W = 6;

   typedef struct packed {
      logic             arm;
      logic [COL_W-1:0] col;
      logic             css;
   } css_entry_t;
endpackage

// File: rtl/raster_timer.sv
module raster_timer #(
   parameter int CPU_DIV           = 4,
   parameter int LINE_CPU          = 57,
   parameter int LINE_CHROMA_SHORT = 227,
   parameter int CNT_W             = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hsync,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_d,
   output logic             new_line,
   output logic             line_start_q
);
   localparam int POS_W = $clog2(LINE_CHROMA_SHORT + 1);
   localparam int PRE_W = $clog2(CPU_DIV);
   localparam logic [POS_W-1:0] LAST_LONG  = POS_W'(LINE_CHROMA_SHORT);
   localparam logic [POS_W-1:0] LAST_SHORT = POS_W'(LINE_CHROMA_SHORT - 1);
   localparam logic [PRE_W-1:0] PRE_LAST   = PRE_W'(CPU_DIV - 1);
   localparam logic [CNT_W-1:0] CNT_LAST   = CNT_W'(LINE_CPU - 1);

   generate
      if (CPU_DIV < 2) begin : g_bad_div
         $error("raster_timer: CPU_DIV must be at least 2");
      end
      if (CNT_W < $clog2(LINE_CPU)) begin : g_bad_cnt
         $error("raster_timer: CNT_W too narrow for LINE_CPU");
      end
   endgenerate

   logic             hs_q;
   logic             hs_rise;
   logic             eol;
   logic             step;
   logic             long_q;
   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] pos_d;
   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] pre_d;

   always_comb begin
      hs_rise  = hsync & ~hs_q;
      eol      = (pos_q == (long_q ? LAST_LONG : LAST_SHORT));
      new_line = hs_rise | eol;
      step     = (pre_q == PRE_LAST);
      pos_d    = new_line ? '0 : pos_q + 1'b1;
      pre_d    = (new_line || step) ? '0 : pre_q + 1'b1;
      if (new_line)
         cnt_d = '0;
      else if (step)
         cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
      else
         cnt_d = cnt_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_q         <= 1'b0;
         pos_q        <= '0;
         pre_q        <= '0;
         cnt_q        <= '0;
         long_q       <= 1'b0;
         line_start_q <= 1'b0;
      end else begin
         hs_q         <= hsync;
         pos_q        <= pos_d;
         pre_q        <= pre_d;
         cnt_q        <= cnt_d;
         line_start_q <= new_line;
         if (hs_rise)
            long_q <= 1'b0;
         else if (eol)
            long_q <= ~long_q;
      end
   end

   assert_cnt_bound_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CNT_W'(LINE_CPU));

   assert_cnt_step_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      !new_line |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1
                     || (cnt_q == '0 && $past(cnt_q) == CNT_LAST)));

   assert_sync_restart_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      hs_rise |=> (cnt_q == '0 && line_start_q));

   assert_strobe_zero_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      line_start_q |-> (cnt_q == '0 && pre_q == '0));
endmodule

// File: rtl/css_table.sv
module css_table
   import css_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  css_entry_t               wr_data,
   input  logic                     swap,
   output css_entry_t [ENTRIES-1:0] act_o
);
   generate
      if (ENTRIES < 1 || ENTRIES > (1 << IDX_W)) begin : g_bad_depth
         $error("css_table: ENTRIES does not fit IDX_W");
      end
   endgenerate

   css_entry_t [ENTRIES-1:0] shadow_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_q <= '0;
         act_o    <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && wr_idx == IDX_W'(i))
               shadow_q[i] <= wr_data;
         end
         if (swap)
            act_o <= shadow_q;
      end
   end
endmodule

// File: rtl/css_matcher.sv
module css_matcher
   import css_pkg::*;
#(
   parameter int ENTRIES   = 8,
   parameter int CNT_W     = 6,
   parameter int VIS_BYTES = 32,
   parameter int LEAD      = 13,
   parameter int ALT_SHIFT = 4,
   parameter bit HIGH_WINS = 1'b1
) (
   input  css_entry_t [ENTRIES-1:0] act,
   input  logic [CNT_W-1:0]         cnt_nxt,
   input  logic                     alt,
   output logic                     hit,
   output logic                     val
);
   localparam int TW = ((COL_W > CNT_W) ? COL_W : CNT_W) + 1;
   localparam logic [TW-1:0] OFF_N = TW'(LEAD);
   localparam logic [TW-1:0] OFF_A = TW'(LEAD - ALT_SHIFT);
   localparam logic [COL_W-1:0] COL_MAX = COL_W'(VIS_BYTES);

   logic [ENTRIES-1:0] match;

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
         logic          ok;
         logic [TW-1:0] tgt;
         assign ok       = act[i].arm && (act[i].col != '0) && (act[i].col <= COL_MAX);
         assign tgt      = TW'(act[i].col) + (alt ? OFF_A : OFF_N);
         assign match[i] = ok && (tgt == TW'(cnt_nxt));
      end

      if (HIGH_WINS) begin : g_high
         always_comb begin
            hit = 1'b0;
            val = 1'b0;
            for (int i = 0; i < ENTRIES; i++) begin
               if (match[i]) begin
                  hit = 1'b1;
                  val = act[i].css;
               end
            end
         end
      end else begin : g_low
         always_comb begin
            hit = 1'b0;
            val = 1'b0;
            for (int i = ENTRIES - 1; i >= 0; i--) begin
               if (match[i]) begin
                  hit = 1'b1;
                  val = act[i].css;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/raster_css_switcher.sv
module raster_css_switcher
   import css_pkg::*;
#(
   parameter int ENTRIES           = 8,
   parameter int CPU_DIV           = 4,
   parameter int LINE_CPU          = 57,
   parameter int LINE_CHROMA_SHORT = 227,
   parameter int VIS_BYTES         = 32,
   parameter int LEAD              = 13,
   parameter int ALT_SHIFT         = 4,
   parameter bit HIGH_WINS         = 1'b1
) (
   input  logic             clk_chroma,
   input  logic             rst_n,
   input  logic             hsync,
   input  logic             alt_mode,
   input  logic             wr_en,
   input  logic [2:0]       wr_idx,
   input  logic             wr_arm,
   input  logic [5:0]       wr_col,
   input  logic             wr_css,
   output logic             css,
   output logic [5:0]       byte_col,
   output logic             visible,
   output logic             line_start
);
   localparam int IDX_W = 3;
   localparam int CNT_W = $clog2(LINE_CPU);
   localparam logic [CNT_W-1:0] OFF_N = CNT_W'(LEAD);
   localparam logic [CNT_W-1:0] OFF_A = CNT_W'(LEAD - ALT_SHIFT);
   localparam logic [CNT_W-1:0] SPAN  = CNT_W'(VIS_BYTES);

   generate
      if (LINE_CPU * CPU_DIV != LINE_CHROMA_SHORT + 1) begin : g_bad_line
         $error("raster_css_switcher: long line must equal LINE_CPU*CPU_DIV");
      end
      if (LEAD + VIS_BYTES >= LINE_CPU) begin : g_bad_window
         $error("raster_css_switcher: visible window exceeds the line");
      end
      if (ALT_SHIFT >= LEAD) begin : g_bad_shift
         $error("raster_css_switcher: ALT_SHIFT must be below LEAD");
      end
      if (VIS_BYTES >= (1 << COL_W) || ENTRIES > (1 << IDX_W)) begin : g_bad_width
         $error("raster_css_switcher: column or index field too narrow");
      end
   endgenerate

   logic [CNT_W-1:0]         cnt_q;
   logic [CNT_W-1:0]         cnt_d;
   logic                     new_line;
   logic                     alt_q;
   logic                     css_q;
   logic                     hit;
   logic                     hit_val;
   logic                     vis;
   logic [CNT_W-1:0]         off;
   css_entry_t               wr_data;
   css_entry_t [ENTRIES-1:0] act;

   raster_timer #(
      .CPU_DIV          (CPU_DIV),
      .LINE_CPU         (LINE_CPU),
      .LINE_CHROMA_SHORT(LINE_CHROMA_SHORT),
      .CNT_W            (CNT_W)
   ) u_timer (
      .clk         (clk_chroma),
      .rst_n       (rst_n),
      .hsync       (hsync),
      .cnt_q       (cnt_q),
      .cnt_d       (cnt_d),
      .new_line    (new_line),
      .line_start_q(line_start)
   );

   assign wr_data = '{arm: wr_arm, col: wr_col, css: wr_css};

   css_table #(
      .ENTRIES(ENTRIES),
      .IDX_W  (IDX_W)
   ) u_tbl (
      .clk    (clk_chroma),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_data(wr_data),
      .swap   (new_line),
      .act_o  (act)
   );

   css_matcher #(
      .ENTRIES  (ENTRIES),
      .CNT_W    (CNT_W),
      .VIS_BYTES(VIS_BYTES),
      .LEAD     (LEAD),
      .ALT_SHIFT(ALT_SHIFT),
      .HIGH_WINS(HIGH_WINS)
   ) u_match (
      .act    (act),
      .cnt_nxt(cnt_d),
      .alt    (alt_q),
      .hit    (hit),
      .val    (hit_val)
   );

   always_ff @(posedge clk_chroma) begin
      if (!rst_n) begin
         alt_q <= 1'b0;
         css_q <= 1'b0;
      end else begin
         if (new_line)
            alt_q <= alt_mode;
         if (hit)
            css_q <= hit_val;
      end
   end

   always_comb begin
      off      = alt_q ? OFF_A : OFF_N;
      vis      = (cnt_q > off) && (cnt_q <= off + SPAN);
      byte_col = vis ? COL_W'(cnt_q - off) : '0;
   end

   assign css     = css_q;
   assign visible = vis;

   assert_first_col_R3 : assert property (@(posedge clk_chroma) disable iff (!rst_n)
      $rose(vis) |-> byte_col == 6'd1);

   assert_css_in_window_R5 : assert property (@(posedge clk_chroma) disable iff (!rst_n)
      !$stable(css_q) |-> vis);

   assert_table_swap_R10 : assert property (@(posedge clk_chroma) disable iff (!rst_n)
      !$stable(act) |-> line_start);

   assert_mode_hold_R12 : assert property (@(posedge clk_chroma) disable iff (!rst_n)
      !$stable(alt_q) |-> line_start);
endmodule

// File: tb/sim_raster_css_switcher.sv
module sim_raster_css_switcher;
   import css_pkg::*;

   localparam int CLK_PERIOD = 8;
   localparam int QTR        = CLK_PERIOD / 4;

   logic       clk = 1'b0;
   logic       rst_n, hsync, alt_mode, wr_en, wr_arm, wr_css;
   logic [2:0] wr_idx;
   logic [5:0] wr_col;
   logic       css, visible, line_start;
   logic [5:0] byte_col;

   int checks = 0;
   int errors = 0;
   int cur    = 0;
   int mpos   = 0;
   logic css_prev = 1'b0;
   logic mon_on   = 1'b0;

   typedef struct { int pos; logic val; string tag; } exp_t;
   exp_t xq[$];
   exp_t e;

   css_entry_t m_sh [8];
   css_entry_t m_act[8];
   logic       m_css = 1'b0;

   raster_css_switcher u0 (
      .clk_chroma(clk), .rst_n(rst_n), .hsync(hsync), .alt_mode(alt_mode),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_arm(wr_arm), .wr_col(wr_col),
      .wr_css(wr_css), .css(css), .byte_col(byte_col), .visible(visible),
      .line_start(line_start)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   // monitor: pops expected css transitions and compares clock offset and value
   always @(negedge clk) begin
      if (rst_n && mon_on) begin
         if (line_start) mpos = 0; else mpos++;
         if (css !== css_prev) begin
            checks++;
            if (xq.size() == 0) begin
               errors++;
               $display("FAIL R9 unexpected css change actual=%0b expected=%0b pos=%0d", css, css_prev, mpos);
            end else begin
               e = xq.pop_front();
               if (e.pos != mpos || e.val !== css) begin
                  errors++;
                  $display("FAIL %s css switch actual=pos%0d/%0b expected=pos%0d/%0b",
                           e.tag, mpos, css, e.pos, e.val);
               end
            end
         end
         css_prev = css;
      end
   end

   task automatic step1();
      @(posedge clk); #QTR;
      cur++;
   endtask

   task automatic goto_pos(int p);
      while (cur < p) step1();
   endtask

   task automatic wait_line();
      forever begin
         @(posedge clk); #QTR;
         if (line_start) break;
      end
      cur = 0;
   endtask

   // driver: at each line start, load model table and push predicted switches
   task automatic begin_line(string tag);
      int off;
      wait_line();
      chk("R5 pending switches at line end", xq.size(), 0);
      xq.delete();
      for (int i = 0; i < 8; i++) m_act[i] = m_sh[i];
      off = alt_mode ? 9 : 13;
      for (int c = 1; c <= 32; c++) begin
         logic h = 1'b0;
         logic v = 1'b0;
         for (int i = 0; i < 8; i++)
            if (m_act[i].arm && int'(m_act[i].col) == c) begin h = 1'b1; v = m_act[i].css; end
         if (h && v != m_css) begin
            xq.push_back('{pos: 4 * (off + c), val: v, tag: tag});
            m_css = v;
         end
      end
   endtask

   task automatic write_entry(int idx, bit arm, int col, bit cv);
      wr_en = 1'b1; wr_idx = 3'(idx); wr_arm = arm; wr_col = 6'(col); wr_css = cv;
      m_sh[idx] = '{arm: arm, col: 6'(col), css: cv};
      step1();
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int g1, g2, strobes;
      rst_n = 1'b0; hsync = 1'b0; alt_mode = 1'b0;
      wr_en = 1'b0; wr_idx = '0; wr_arm = 1'b0; wr_col = '0; wr_css = 1'b0;
      for (int i = 0; i < 8; i++) m_sh[i] = '0;
      repeat (5) @(posedge clk);
      #QTR;
      chk("R1 css", int'(css), 0);
      chk("R1 byte_col", int'(byte_col), 0);
      chk("R1 visible", int'(visible), 0);
      chk("R1 line_start", int'(line_start), 0);
      rst_n = 1'b1;
      mon_on = 1'b1;

      // R2: strobe spacing alternates
      wait_line();
      g1 = 0; do begin @(posedge clk); #QTR; g1++; end while (!line_start);
      g2 = 0; do begin @(posedge clk); #QTR; g2++; end while (!line_start);
      chk("R2 long line", g1, 228);
      chk("R2 short line", g2, 227);

      // R3 window in normal mode, R12 mode change mid-line ignored
      begin_line("R3");
      goto_pos(10); alt_mode = 1'b1;
      goto_pos(40); chk("R12 visible stays normal", int'(visible), 0);
      goto_pos(55); chk("R3 before window", int'(visible), 0);
      goto_pos(56); chk("R3 first byte vis", int'(visible), 1);
      chk("R3 first byte col", int'(byte_col), 1);
      goto_pos(100); chk("R3 mid col", int'(byte_col), 12);
      goto_pos(183); chk("R3 last byte col", int'(byte_col), 32);
      goto_pos(184); chk("R3 after window vis", int'(visible), 0);
      chk("R3 after window col", int'(byte_col), 0);

      // R4 alternate window
      begin_line("R4");
      goto_pos(39); chk("R4 before window", int'(visible), 0);
      goto_pos(40); chk("R4 first byte col", int'(byte_col), 1);
      goto_pos(167); chk("R4 last byte col", int'(byte_col), 32);
      goto_pos(168); chk("R4 after window", int'(visible), 0);
      alt_mode = 1'b0;
      for (int i = 0; i < 8; i++) write_entry(i, 1'b1, 1 + 4 * i, (i % 2) == 0);

      // R5 eight bars, normal mode
      begin_line("R5");
      goto_pos(20); alt_mode = 1'b1;
      // R6 same bars shifted earlier
      begin_line("R6");
      goto_pos(20); alt_mode = 1'b0;
      write_entry(0, 1'b0, 5, 1'b1);
      write_entry(1, 1'b1, 0, 1'b0);
      write_entry(2, 1'b1, 10, 1'b0);
      write_entry(3, 1'b1, 33, 1'b0);
      write_entry(4, 1'b0, 15, 1'b0);
      write_entry(5, 1'b1, 10, 1'b1);
      write_entry(6, 1'b0, 20, 1'b0);
      write_entry(7, 1'b0, 25, 1'b0);

      // R7 priority, R9 ignored entries
      begin_line("R7");
      goto_pos(220); chk("R9 css unchanged by bad entries", int'(css), 1);

      // R8 hold across line, R10 deferred write
      begin_line("R8");
      chk("R8 css held at line start", int'(css), 1);
      goto_pos(20); write_entry(0, 1'b1, 30, 1'b0);
      goto_pos(180); chk("R10 write deferred", int'(css), 1);
      begin_line("R10");
      goto_pos(180); chk("R10 write applied", int'(css), 0);

      // R11 sync restart
      begin_line("R11");
      goto_pos(5); hsync = 1'b1;
      step1();
      chk("R11 strobe after sync", int'(line_start), 1);
      chk("R11 byte_col after sync", int'(byte_col), 0);
      strobes = 0;
      for (int k = 0; k < 10; k++) begin step1(); if (line_start) strobes++; end
      chk("R11 held sync no restrobe", strobes, 0);
      hsync = 1'b0;
      g1 = 10; do begin @(posedge clk); #QTR; g1++; end while (!line_start);
      chk("R11 short line after sync", g1, 227);
      chk("R5 switches after sync", xq.size(), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule